// File: doc/BRIEF.md
# Ping-Pong Analog Pipeline Address Controller

This block drives the cell addresses and bank selects of two 48-cell switched-capacitor sample pipelines that cannot be written and read in the same bank at once. One bank records while the other is read. A circular write pointer moves forward one cell on every beam-crossing strobe, which arrives once per 132 ns sampling period. The write bank changes at each superbunch-gap marker. The x1 and x8 gain pipelines take the same address and bank outputs.

On a first-level accept, the block works out which cell holds the signal peak. That cell is the write pointer minus a programmable latency in samples, modulo 48. The baseline cell is three samples before the peak cell. The two addresses are held until the next gap marker. At that marker the bank that was recording becomes the read bank, and the block presents the peak cell and then the baseline cell through a valid/ready handshake while the other bank records. An accept that cannot be taken is refused. It sets a sticky overflow flag and increments a saturating counter.

Top module: `pp_cell_seq`

## Requirements
- R1: After a synchronous reset, `wr_cell` is 0, `wr_bank` is 0, `rd_valid` is 0, `ovf_flag` is 0 and `ovf_cnt` is 0.
- R2: Each clock with `xing_stb` high advances `wr_cell` by one, and the value after 47 is 0. With `xing_stb` low, `wr_cell` holds.
- R3: An accept (`l1_acc` high) that is taken captures peak cell = (`wr_cell` − `lat`) mod 48, using the `wr_cell` value in the accept cycle.
- R4: When `gap_mark` is high and no readout is active, `wr_bank` toggles. If a captured event is waiting, then from the next cycle `rd_valid`=1, `rd_bank` = the bank that was recording, `rd_cell` = peak and `rd_is_base`=0.
- R5: While `rd_valid` is 1, `rd_bank` differs from `wr_bank`, and a `gap_mark` leaves `wr_bank` unchanged.
- R6: A handshake (`rd_valid` and `rd_ready`) on the peak makes `rd_cell` = (peak − 3) mod 48 with `rd_is_base`=1 in the next cycle. A handshake on the baseline clears `rd_valid` in the next cycle.
- R7: While `rd_valid` is 1 and `rd_ready` is 0, `rd_cell` and `rd_is_base` hold and `rd_valid` stays 1.
- R8: An accept is refused if an event is waiting, if a readout is active, or if it coincides with `gap_mark`. A refused accept leaves the waiting event unchanged, sets `ovf_flag` until reset, and adds one to `ovf_cnt`, which saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_stb | input | 1 | Beam-crossing strobe, advances write pointer |
| gap_mark | input | 1 | Superbunch-gap marker, bank swap point |
| l1_acc | input | 1 | First-level accept |
| lat | input | 6 | Trigger latency in samples (0..47) |
| rd_ready | input | 1 | Readout consumer ready |
| wr_cell | output | 6 | Cell being written |
| wr_bank | output | 1 | Bank being written |
| rd_valid | output | 1 | Read address valid |
| rd_cell | output | 6 | Cell being read |
| rd_bank | output | 1 | Bank being read |
| rd_is_base | output | 1 | 1 when `rd_cell` is the baseline cell |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_cnt | output | 8 | Count of refused accepts, saturating |

## Verification
All outputs come from registers. A stimulus applied before a rising edge therefore shows its effect exactly one cycle later: the pointer step, the bank swap, the start of readout with the peak cell, the step to the baseline cell, the drop of `rd_valid` and the overflow count. The bench drives every input on the falling edge and samples on the next falling edge, after exactly one rising edge. It keeps its own model of pointer, bank and tag arithmetic, so each result is compared in the cycle it is due. Hold behaviour is checked in each cycle of a stalled handshake.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;
  // (a - b) mod n, operands assumed below n for a, any value for b
  function automatic int unsigned sub_mod(input int unsigned a, input int unsigned b,
                                          input int unsigned n);
    return (a + n - (b % n)) % n;
  endfunction
endpackage

// File: rtl/pp_ring_ptr.sv
module pp_ring_ptr #(
  parameter int CELLS = 48,
  parameter int AW    = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(CELLS - 1);

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (adv)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr)); // R2
endmodule

// File: rtl/pp_event_tag.sv
module pp_event_tag
  import pp_seq_pkg::*;
#(
  parameter int CELLS    = 48,
  parameter int AW       = $clog2(CELLS),
  parameter int BASE_OFS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          clear,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] lat,
  output logic          pend,
  output logic [AW-1:0] peak,
  output logic [AW-1:0] base
);
  logic [AW-1:0] peak_c, base_c;

  always_comb begin
    peak_c = AW'(sub_mod(int'(wr_ptr), int'(lat), CELLS));
    base_c = AW'(sub_mod(int'(peak_c), BASE_OFS, CELLS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      peak <= '0;
      base <= '0;
    end else if (take) begin
      pend <= 1'b1;
      peak <= peak_c;
      base <= base_c;
    end else if (clear) begin
      pend <= 1'b0;
    end
  end

  AST_TAG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    pend && !take |=> $stable(peak) && $stable(base)); // R8
endmodule

// File: rtl/pp_readout_seq.sv
module pp_readout_seq
  import pp_seq_pkg::*;
#(
  parameter int CELLS    = 48,
  parameter int AW       = $clog2(CELLS),
  parameter int BASE_OFS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bank_in,
  input  logic [AW-1:0] peak,
  input  logic [AW-1:0] base,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [AW-1:0] rd_cell,
  output logic          rd_bank,
  output logic          rd_is_base
);
  logic [AW-1:0] base_hold;
  logic          hs;

  assign hs = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_cell    <= '0;
      rd_bank    <= 1'b0;
      rd_is_base <= 1'b0;
      base_hold  <= '0;
    end else if (start && !rd_valid) begin
      rd_valid   <= 1'b1;
      rd_cell    <= peak;
      rd_bank    <= bank_in;
      rd_is_base <= 1'b0;
      base_hold  <= base;
    end else if (hs) begin
      if (!rd_is_base) begin
        rd_cell    <= base_hold;
        rd_is_base <= 1'b1;
      end else begin
        rd_valid   <= 1'b0;
      end
    end
  end

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    hs && !rd_is_base |=> rd_valid && rd_is_base &&
      (int'(rd_cell) == sub_mod(int'($past(rd_cell)), BASE_OFS, CELLS))); // R6
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_cell) && $stable(rd_is_base)); // R7
  AST_READ_END: assert property (@(posedge clk) disable iff (rst)
    hs && rd_is_base |=> !rd_valid); // R6
endmodule

// File: rtl/pp_cell_seq.sv
module pp_cell_seq #(
  parameter int CELLS    = 48,
  parameter int AW       = $clog2(CELLS),
  parameter int BASE_OFS = 3,
  parameter int OVF_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xing_stb,
  input  logic             gap_mark,
  input  logic             l1_acc,
  input  logic [AW-1:0]    lat,
  input  logic             rd_ready,
  output logic [AW-1:0]    wr_cell,
  output logic             wr_bank,
  output logic             rd_valid,
  output logic [AW-1:0]    rd_cell,
  output logic             rd_bank,
  output logic             rd_is_base,
  output logic             ovf_flag,
  output logic [OVF_W-1:0] ovf_cnt
);
  localparam logic [OVF_W-1:0] CNT_MAX = '1;

  logic          pend, busy, take, refuse, swap, start;
  logic [AW-1:0] peak, base;

  assign busy   = pend | rd_valid;
  assign take   = l1_acc & ~busy & ~gap_mark;
  assign refuse = l1_acc & ~take;
  assign swap   = gap_mark & ~rd_valid;
  assign start  = swap & pend;

  pp_ring_ptr #(.CELLS(CELLS), .AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .adv(xing_stb), .ptr(wr_cell)
  );

  pp_event_tag #(.CELLS(CELLS), .AW(AW), .BASE_OFS(BASE_OFS)) u_tag (
    .clk(clk), .rst(rst), .take(take), .clear(start),
    .wr_ptr(wr_cell), .lat(lat), .pend(pend), .peak(peak), .base(base)
  );

  pp_readout_seq #(.CELLS(CELLS), .AW(AW), .BASE_OFS(BASE_OFS)) u_rd (
    .clk(clk), .rst(rst), .start(start), .bank_in(wr_bank),
    .peak(peak), .base(base), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_cell(rd_cell), .rd_bank(rd_bank), .rd_is_base(rd_is_base)
  );

  always_ff @(posedge clk) begin
    if (rst)       wr_bank <= 1'b0;
    else if (swap) wr_bank <= ~wr_bank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      ovf_cnt  <= '0;
    end else if (refuse) begin
      ovf_flag <= 1'b1;
      if (ovf_cnt != CNT_MAX) ovf_cnt <= ovf_cnt + 1'b1;
    end
  end

  AST_RD_OTHER_BANK: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_bank != wr_bank); // R5
  AST_NO_SWAP_IN_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid && gap_mark |=> $stable(wr_bank)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag); // R8
  AST_OVF_COUNT: assert property (@(posedge clk) disable iff (rst)
    l1_acc && busy && ovf_cnt != CNT_MAX |=> ovf_cnt == $past(ovf_cnt) + 1'b1); // R8
  AST_START_READ: assert property (@(posedge clk) disable iff (rst)
    gap_mark && pend && !rd_valid |=> rd_valid && !rd_is_base); // R4
endmodule

// File: tb/pp_cell_seq_tb.sv
module pp_cell_seq_tb;
  localparam int CELLS = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xing_stb = 1'b0, gap_mark = 1'b0, l1_acc = 1'b0, rd_ready = 1'b0;
  logic [5:0] lat = '0;
  logic [5:0] wr_cell, rd_cell;
  logic       wr_bank, rd_valid, rd_bank, rd_is_base, ovf_flag;
  logic [7:0] ovf_cnt;

  int checks = 0, errors = 0;
  int exp_wr = 0;
  int exp_bank = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pp_cell_seq u_dut (
    .clk(clk), .rst(rst), .xing_stb(xing_stb), .gap_mark(gap_mark), .l1_acc(l1_acc),
    .lat(lat), .rd_ready(rd_ready), .wr_cell(wr_cell), .wr_bank(wr_bank),
    .rd_valid(rd_valid), .rd_cell(rd_cell), .rd_bank(rd_bank), .rd_is_base(rd_is_base),
    .ovf_flag(ovf_flag), .ovf_cnt(ovf_cnt)
  );

  function automatic int smod(int a, int b);
    return ((a - b) % CELLS + CELLS) % CELLS;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive on falling edge, sample on the next falling edge
  task automatic cyc(bit xs, bit gp, bit ac, bit rr);
    xing_stb = xs; gap_mark = gp; l1_acc = ac; rd_ready = rr;
    @(negedge clk);
    if (xs) exp_wr = (exp_wr + 1) % CELLS;
    xing_stb = 0; gap_mark = 0; l1_acc = 0; rd_ready = 0;
  endtask

  task automatic t_reset;
    chk("R1 wr_cell", wr_cell, 0);
    chk("R1 wr_bank", wr_bank, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 ovf_cnt", ovf_cnt, 0);
  endtask

  task automatic t_pointer;
    for (int i = 0; i < 47; i++) cyc(1, 0, 0, 0);
    chk("R2 reach 47", wr_cell, 47);
    cyc(1, 0, 0, 0);
    chk("R2 wrap", wr_cell, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R2 hold", wr_cell, 0);
    cyc(1, 0, 0, 0);
    chk("R2 step", wr_cell, exp_wr);
  endtask

  // accept, swap, read peak and baseline with stalls
  task automatic t_event(int l);
    int w, pk, bs, b0;
    lat = 6'(l);
    w = exp_wr;
    pk = smod(w, l);
    bs = smod(pk, 3);
    cyc(1, 0, 1, 0);
    chk("R4 no read before gap", rd_valid, 0);
    b0 = exp_bank;
    cyc(0, 1, 0, 0);
    exp_bank ^= 1;
    chk("R4 swap", wr_bank, exp_bank);
    chk("R4 rd_valid", rd_valid, 1);
    chk("R4 rd_bank", rd_bank, b0);
    chk("R3 peak cell", rd_cell, pk);
    chk("R4 rd_is_base", rd_is_base, 0);
    cyc(1, 0, 0, 0);
    chk("R7 hold cell", rd_cell, pk);
    chk("R7 hold valid", rd_valid, 1);
    cyc(0, 1, 0, 0);
    chk("R5 no swap in read", wr_bank, exp_bank);
    chk("R7 hold after gap", rd_cell, pk);
    cyc(0, 0, 0, 1);
    chk("R6 base cell", rd_cell, bs);
    chk("R6 is_base", rd_is_base, 1);
    cyc(0, 0, 0, 1);
    chk("R6 end", rd_valid, 0);
  endtask

  task automatic t_overflow;
    int w, pk;
    lat = 6'd10;
    w = exp_wr;
    pk = smod(w, 10);
    cyc(1, 0, 1, 0);                // taken
    cyc(1, 0, 1, 0);                // refused: event waiting
    chk("R8 flag", ovf_flag, 1);
    chk("R8 count", ovf_cnt, 1);
    cyc(0, 1, 0, 0);
    exp_bank ^= 1;
    chk("R8 first event kept", rd_cell, pk);
    cyc(0, 0, 1, 0);                // refused: reading
    chk("R8 count in read", ovf_cnt, 2);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    chk("R8 read done", rd_valid, 0);
    cyc(0, 1, 1, 0);                // refused: coincides with gap
    exp_bank ^= 1;
    chk("R8 gap accept refused", ovf_cnt, 3);
    chk("R4 swap when idle", wr_bank, exp_bank);
    cyc(0, 1, 0, 0);
    exp_bank ^= 1;
    chk("R8 nothing captured", rd_valid, 0);
    cyc(0, 0, 0, 0);
    chk("R8 sticky", ovf_flag, 1);
    cyc(0, 0, 1, 0);                // taken
    for (int i = 0; i < 260; i++) cyc(0, 0, 1, 0);
    chk("R8 saturate", ovf_cnt, 255);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    t_reset();
    t_pointer();
    t_event(5);
    t_event(0);
    t_event(47);
    t_overflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule